// File: doc/BRIEF.md
# Variable-Latency Register Lock Scoreboard

This block keeps program order intact on a dual-issue core whose decode stage sends an instruction pair into two parallel channels. One shared functional unit has a completion time that cannot be predicted. An instruction sent to that unit can name up to four source registers and two destination registers. When such an instruction issues, its destination registers become locked. Each lock is released when the unit hands that register back on one of its dedicated writeback ports.

While a lock is held, any instruction pair that reads or writes the locked register is held back. The stall output goes to fetch and decode. Both slots always stall together, because a pair is never split. The stalled pair is checked again on every cycle. It issues on the first cycle in which none of its operands is locked.

The lock table holds one bit per architectural register. Register 0 is hardwired and never locked. All other hazards are handled outside this block by bypassing.

Top module: `vlu_lock_sb`

## Requirements
- R1: With reset asserted (rst_n low, asynchronous), every lock is cleared and no pair is stalled until a lock is set again after release.
- R2: A pair that is valid and not stalled locks every valid, nonzero destination of each slot whose slot_vl bit is 1. The lock is visible from the next cycle on. Destinations of a slot with slot_vl 0 set no lock.
- R3: Register 0 never becomes locked, whatever names it.
- R4: stall is high in the same cycle as pair_valid when any valid source field of either slot (slot s, field k at index s*SRC_PER_SLOT+k) names a locked register (read after write).
- R5: stall is also high when any valid destination field of either slot names a locked register (write after write). This includes a further variable-latency issue to a register that is still locked.
- R6: A stalled pair sets no lock in either slot. It is presented again and judged afresh on every cycle.
- R7: A valid writeback on any port clears the lock of its register at the next clock edge. A pair waiting on that register is still stalled in the writeback cycle and is released in the following cycle.
- R8: When a writeback clears a register in the same edge that an issuing pair locks it, the register ends up locked.
- R9: With pair_valid low, stall is low and no lock is set.
- R10: A source, destination or writeback field whose valid bit is 0 has no effect on stall or on the lock table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_valid | input | 1 | An instruction pair is presented for issue |
| src_addr | input | 2*SRC_PER_SLOT*AW | Source register numbers, slot-major |
| src_vld | input | 2*SRC_PER_SLOT | Valid bit for each source field |
| dst_addr | input | 2*DST_PER_SLOT*AW | Destination register numbers, slot-major |
| dst_vld | input | 2*DST_PER_SLOT | Valid bit for each destination field |
| slot_vl | input | 2 | Slot carries an instruction for the variable-latency unit |
| wb_vld | input | WB_PORTS | Writeback accepted on that port |
| wb_addr | input | WB_PORTS*AW | Register written back on each port |
| stall | output | 1 | Hold the whole pair in fetch and decode |

## Verification
stall depends combinationally on the current inputs and the registered lock table. The bench therefore compares it in the same cycle in which a pair is driven, shortly after the falling edge. A lock set by an issue or cleared by a writeback takes effect at the next rising edge, so its result can only be seen one cycle later. The bench's register model changes at that same edge, and every follow-up probe of a lock is placed in the cycle after the stimulus. Directed sweeps over every register are followed by a pseudo-random run, and both are compared cycle by cycle against that model.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int NUM_SLOTS = 2;

   typedef enum logic [1:0] {
      LK_HOLD = 2'd0,
      LK_SET  = 2'd1,
      LK_CLR  = 2'd2
   } lk_act_e;
endpackage

// File: rtl/sb_addr_decode.sv
module sb_addr_decode #(
   parameter int NREG = 32,
   parameter int AW   = 5,
   parameter int N    = 4
) (
   input  logic [N*AW-1:0] addr,
   input  logic [N-1:0]    vld,
   output logic [NREG-1:0] mask
);
   always_comb begin
      mask = '0;
      for (int i = 0; i < N; i++) begin
         if (vld[i] && (addr[i*AW +: AW] != '0) && (32'(addr[i*AW +: AW]) < NREG))
            mask[addr[i*AW +: AW]] = 1'b1;
      end
   end
endmodule

// File: rtl/sb_lock_table.sv
module sb_lock_table
   import sb_pkg::*;
#(
   parameter int NREG = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREG-1:0] set_mask,
   input  logic [NREG-1:0] clr_mask,
   output logic [NREG-1:0] lock_q
);
   for (genvar r = 0; r < NREG; r++) begin : g_bit
      if (r == 0) begin : g_zero
         logic unused_zero;
         assign unused_zero = set_mask[0] | clr_mask[0];
         assign lock_q[0]   = 1'b0;
      end else begin : g_live
         lk_act_e act;
         logic    q;
         always_comb begin
            if (set_mask[r])      act = LK_SET;
            else if (clr_mask[r]) act = LK_CLR;
            else                  act = LK_HOLD;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else begin
               case (act)
                  LK_SET:  q <= 1'b1;
                  LK_CLR:  q <= 1'b0;
                  default: q <= q;
               endcase
            end
         end
         assign lock_q[r] = q;
      end
   end
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
   parameter int NREG = 32
) (
   input  logic            pair_valid,
   input  logic [NREG-1:0] lock_q,
   input  logic [NREG-1:0] rd_mask,
   input  logic [NREG-1:0] wr_mask,
   output logic            stall,
   output logic            issue
);
   logic raw_hit, waw_hit;
   assign raw_hit = |(lock_q & rd_mask);
   assign waw_hit = |(lock_q & wr_mask);
   assign stall   = pair_valid & (raw_hit | waw_hit);
   assign issue   = pair_valid & ~(raw_hit | waw_hit);
endmodule

// File: rtl/vlu_lock_sb.sv
module vlu_lock_sb
   import sb_pkg::*;
#(
   parameter int NREG         = 32,
   parameter int SRC_PER_SLOT = 4,
   parameter int DST_PER_SLOT = 2,
   parameter int WB_PORTS     = 2,
   localparam int AW          = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int NS          = NUM_SLOTS * SRC_PER_SLOT,
   localparam int ND          = NUM_SLOTS * DST_PER_SLOT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pair_valid,
   input  logic [NS*AW-1:0]       src_addr,
   input  logic [NS-1:0]          src_vld,
   input  logic [ND*AW-1:0]       dst_addr,
   input  logic [ND-1:0]          dst_vld,
   input  logic [NUM_SLOTS-1:0]   slot_vl,
   input  logic [WB_PORTS-1:0]    wb_vld,
   input  logic [WB_PORTS*AW-1:0] wb_addr,
   output logic                   stall
);
   if (NREG < 2) begin : g_bad_nreg
      $error("vlu_lock_sb: NREG must be at least 2");
   end
   if (SRC_PER_SLOT < 1 || DST_PER_SLOT < 1) begin : g_bad_fields
      $error("vlu_lock_sb: each slot needs a source and a destination field");
   end
   if (WB_PORTS < 1) begin : g_bad_wb
      $error("vlu_lock_sb: at least one writeback port is required");
   end

   logic [NREG-1:0] lock_q, rd_mask, wr_mask, set_mask, clr_mask;
   logic [ND-1:0]   lock_vld;
   logic            issue;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (genvar k = 0; k < DST_PER_SLOT; k++) begin : g_dst
         assign lock_vld[s*DST_PER_SLOT+k] = dst_vld[s*DST_PER_SLOT+k] & slot_vl[s] & issue;
      end
   end

   sb_addr_decode #(.NREG(NREG), .AW(AW), .N(NS)) u_rd_dec (
      .addr(src_addr), .vld(src_vld), .mask(rd_mask));
   sb_addr_decode #(.NREG(NREG), .AW(AW), .N(ND)) u_wr_dec (
      .addr(dst_addr), .vld(dst_vld), .mask(wr_mask));
   sb_addr_decode #(.NREG(NREG), .AW(AW), .N(ND)) u_set_dec (
      .addr(dst_addr), .vld(lock_vld), .mask(set_mask));
   sb_addr_decode #(.NREG(NREG), .AW(AW), .N(WB_PORTS)) u_clr_dec (
      .addr(wb_addr), .vld(wb_vld), .mask(clr_mask));

   sb_hazard #(.NREG(NREG)) u_haz (
      .pair_valid(pair_valid), .lock_q(lock_q), .rd_mask(rd_mask),
      .wr_mask(wr_mask), .stall(stall), .issue(issue));

   sb_lock_table #(.NREG(NREG)) u_tbl (
      .clk(clk), .rst_n(rst_n), .set_mask(set_mask),
      .clr_mask(clr_mask), .lock_q(lock_q));
endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
   parameter int NREG = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pair_valid,
   input logic            stall,
   input logic [NREG-1:0] lock_q,
   input logic [NREG-1:0] set_mask,
   input logic [NREG-1:0] clr_mask
);
   // R3
   reg0_free_chk: assert property (@(posedge clk) disable iff (!rst_n) !lock_q[0]);

   // R9
   stall_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_valid |-> !stall);

   // R6
   no_set_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (set_mask == '0));

   for (genvar r = 1; r < NREG; r++) begin : g_reg
      // R2
      lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_mask[r] |=> lock_q[r]);
      // R7
      lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_mask[r] && !set_mask[r]) |=> !lock_q[r]);
      // R8
      set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_mask[r] && set_mask[r]) |=> lock_q[r]);
      // R2
      rise_only_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !set_mask[r] |=> !$rose(lock_q[r]));
   end
endmodule

bind vlu_lock_sb sb_chk #(.NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .stall(stall),
   .lock_q(lock_q), .set_mask(set_mask), .clr_mask(clr_mask));

// File: tb/sim_vlu_lock_sb.sv
`timescale 1ns/1ps
module sim_vlu_lock_sb;
   localparam int NREG = 8, S = 4, D = 2, W = 2, AW = 3;
   localparam int NS = 2*S, ND = 2*D;

   logic clk = 1'b0, rst_n = 1'b0, pair_valid;
   logic [NS*AW-1:0] src_addr; logic [NS-1:0] src_vld;
   logic [ND*AW-1:0] dst_addr; logic [ND-1:0] dst_vld;
   logic [1:0] slot_vl;
   logic [W-1:0] wb_vld; logic [W*AW-1:0] wb_addr;
   logic stall;

   int checks = 0, fails = 0;
   logic [NREG-1:0] mlock = '0;
   logic [31:0] lfsr = 32'h1ACE_2B3D;
   bit done = 0;

   always #2.5 clk = ~clk;

   vlu_lock_sb #(.NREG(NREG), .SRC_PER_SLOT(S), .DST_PER_SLOT(D), .WB_PORTS(W)) u0 (
      .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .src_addr(src_addr),
      .src_vld(src_vld), .dst_addr(dst_addr), .dst_vld(dst_vld), .slot_vl(slot_vl),
      .wb_vld(wb_vld), .wb_addr(wb_addr), .stall(stall));

   function automatic logic exp_stall();
      logic h = 1'b0;
      if (!pair_valid) return 1'b0;
      for (int i = 0; i < NS; i++) if (src_vld[i] && mlock[src_addr[i*AW +: AW]]) h = 1'b1;
      for (int i = 0; i < ND; i++) if (dst_vld[i] && mlock[dst_addr[i*AW +: AW]]) h = 1'b1;
      return h;
   endfunction

   task automatic idle();
      pair_valid = 1'b0; src_addr = '0; src_vld = '0; dst_addr = '0; dst_vld = '0;
      slot_vl = '0; wb_vld = '0; wb_addr = '0;
   endtask
   task automatic put_src(input int sl, input int k, input int r);
      pair_valid = 1'b1; src_vld[sl*S+k] = 1'b1; src_addr[(sl*S+k)*AW +: AW] = AW'(r);
   endtask
   task automatic put_dst(input int sl, input int k, input int r, input bit vl);
      pair_valid = 1'b1; dst_vld[sl*D+k] = 1'b1; dst_addr[(sl*D+k)*AW +: AW] = AW'(r);
      if (vl) slot_vl[sl] = 1'b1;
   endtask
   task automatic put_wb(input int p, input int r);
      wb_vld[p] = 1'b1; wb_addr[p*AW +: AW] = AW'(r);
   endtask

   // Called just after a falling edge with inputs set; checks stall, then advances one cycle.
   task automatic cyc(input string tag);
      logic e;
      logic [NREG-1:0] nxt;
      #1;
      e = exp_stall();
      checks++;
      if (stall !== e) begin
         fails++;
         $display("FAIL %s: stall actual=%b expected=%b at %0t", tag, stall, e, $time);
      end
      @(posedge clk); #0.5;
      nxt = mlock;
      for (int p = 0; p < W; p++) if (wb_vld[p]) nxt[wb_addr[p*AW +: AW]] = 1'b0;
      if (pair_valid && !e)
         for (int s = 0; s < 2; s++)
            for (int k = 0; k < D; k++)
               if (slot_vl[s] && dst_vld[s*D+k]) nxt[dst_addr[(s*D+k)*AW +: AW]] = 1'b1;
      nxt[0] = 1'b0;
      if (!rst_n) nxt = '0;
      mlock = nxt;
      @(negedge clk);
   endtask

   initial begin
      #(200000.0 * 5.0);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle();
      @(negedge clk);
      // R1: stall low while in reset
      put_src(0, 0, 3); cyc("R1");
      rst_n = 1'b1; idle();
      // R1: nothing locked after release
      for (int r = 0; r < NREG; r++) put_src(r / S, r % S, r);
      cyc("R1");

      for (int r = 1; r < NREG; r++) begin
         int sl = r % 2, q = (r == NREG-1) ? 1 : r + 1;
         idle(); put_dst(sl, r % 2, r, 1); cyc("R2");
         idle(); put_src(1-sl, r % S, r); cyc("R4");
         // R6: stalled pair carries a VL destination q
         idle(); put_src(sl, 0, r); put_dst(1-sl, 0, q, 1); cyc("R6");
         idle(); put_src(0, 1, q); cyc("R6");
         idle(); put_dst(1-sl, 1, r, 0); cyc("R5");
         idle(); put_dst(sl, 0, r, 1); cyc("R5");
         idle(); put_src(0, 2, r); put_wb(r % 2, r); cyc("R7");
         idle(); put_src(0, 2, r); cyc("R7");
      end

      // R8: set and clear on the same edge
      for (int r = 1; r < NREG; r++) begin
         idle(); put_dst(0, 0, r, 1); put_wb(1, r); cyc("R8");
         idle(); put_src(1, 3, r); cyc("R8");
         idle(); put_wb(0, r); cyc("R7");
      end

      // R3: register 0
      idle(); put_dst(0, 0, 0, 1); put_dst(1, 1, 0, 1); cyc("R3");
      idle(); put_src(0, 0, 0); put_dst(1, 0, 0, 0); cyc("R3");

      // R2: non-VL slot sets no lock
      idle(); put_dst(1, 0, 5, 0); cyc("R2");
      idle(); put_src(0, 0, 5); cyc("R2");

      // R10: invalid fields ignored
      idle(); put_dst(0, 1, 3, 1); cyc("R10");
      idle(); put_src(1, 0, 3); src_vld = '0; cyc("R10");
      idle(); wb_addr = AW'(3); cyc("R10");
      idle(); put_src(0, 0, 3); cyc("R10");
      idle(); put_dst(0, 0, 6, 1); dst_vld = '0; cyc("R10");
      idle(); put_src(0, 0, 6); cyc("R10");
      idle(); put_wb(0, 3); cyc("R7");

      // R9: pair_valid low
      idle(); put_dst(0, 0, 2, 1); cyc("R9");
      idle(); put_src(0, 0, 2); pair_valid = 1'b0; cyc("R9");
      idle(); put_wb(0, 2); cyc("R7");
      idle(); put_dst(1, 0, 6, 1); pair_valid = 1'b0; cyc("R9");
      idle(); put_src(1, 1, 6); cyc("R9");

      // Pseudo-random run against the model (R4, R5, R6, R7)
      for (int n = 0; n < 600; n++) begin
         idle();
         for (int i = 0; i < NS; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            src_vld[i] = (lfsr[3:0] < 4'd3); src_addr[i*AW +: AW] = lfsr[10:8];
         end
         for (int i = 0; i < ND; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            dst_vld[i] = lfsr[5]; dst_addr[i*AW +: AW] = lfsr[14:12];
         end
         for (int p = 0; p < W; p++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wb_vld[p] = lfsr[7]; wb_addr[p*AW +: AW] = lfsr[19:17];
         end
         slot_vl = lfsr[25:24]; pair_valid = lfsr[28] | lfsr[29];
         cyc("R4");
      end

      // R1: reset clears a live lock
      idle(); put_dst(0, 0, 4, 1); cyc("R2");
      idle(); rst_n = 1'b0; cyc("R1");
      rst_n = 1'b1; idle(); put_src(0, 0, 4); cyc("R1");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule